// File: doc/BRIEF.md
# 8-bit ALU with condition codes

This block is the arithmetic and logic stage of an 8-bit accumulator processor. Each cycle it takes an accumulator value, a second operand, a 4-bit operation code and the incoming condition-code flags (half carry H, negative N, zero Z, overflow V, carry C). From these it forms an 8-bit result and a new flag set. The operations are binary add and subtract, with or without carry or borrow, increment, decrement, bitwise invert, two's-complement negate, four shifts and two rotates through carry, and a BCD correction step used after a packed-decimal addition.

The result and the flags are latched on a rising clock edge when the valid strobe is high. Between strobes they hold their values, so the surrounding datapath can read them as the processor's current accumulator result and flag register. Single-operand operations work on the accumulator input. Instruction decode, addressing and memory traffic are handled outside the block.

Top module: `alu8_cc`

## Requirements
- R1: A synchronous reset sets `result_q` and `flags_q` to zero. The reset takes priority over a valid strobe in the same cycle. The flag vector is packed as bit 4 H, bit 3 N, bit 2 Z, bit 1 V, bit 0 C, on both `flags_in` and `flags_q`.
- R2: On a rising edge with `valid_in` high, the outputs take the value computed from that cycle's inputs. With `valid_in` low, both outputs keep their previous values whatever the other inputs do.
- R3: Operation codes on `op_sel`: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 increment, 5 decrement, 6 invert, 7 negate, 8 shift left, 9 arithmetic shift right, 10 logical shift right, 11 rotate left, 12 rotate right, 13 decimal adjust. Codes 0 to 3 use the accumulator A and the operand B. All other codes use A only.
- R4: Add (code 0) and add with carry (code 1, carry-in = C) produce (A+B+cin) mod 256. C is the carry out of bit 7, H is the carry out of bit 3, and V is set on signed overflow.
- R5: Subtract (code 2) and subtract with borrow (code 3, borrow-in = C) produce (A-B-bin) mod 256. C is set when the true difference is negative, V is set on signed overflow, and H is unchanged.
- R6: Increment sets V only when the result is 0x80. Decrement sets V only when the result is 0x7F. Both leave C and H unchanged.
- R7: Invert produces the bitwise complement of A, clears V, sets C and leaves H unchanged.
- R8: Negate produces (0 - A) mod 256. V is set only when the result is 0x80, C is set when the result is nonzero, and H is unchanged.
- R9: Shift left and rotate left move bit 7 into C. The vacated bit 0 gets 0 for shift left and the old C for rotate left. The three right moves send bit 0 to C. Bit 7 keeps its old value for the arithmetic shift, becomes 0 for the logical shift and becomes the old C for the rotate.
- R10: After any shift or rotate, V equals the new N xor the new C, and H is unchanged.
- R11: Decimal adjust adds 0x06 when the low nibble of A is above 9 or H is set. It adds 0x60 when the high nibble is above 9, or C is set, or the high nibble is above 8 while the low nibble is above 9. The result is the 8-bit sum.
- R12: After decimal adjust, V is 0, H is unchanged, and C becomes the old C ORed with the carry out of the 9-bit adjusted sum, so decimal adjust never clears C.
- R13: For codes 0 to 13, N equals result bit 7 and Z is set exactly when the 8-bit result is zero.
- R14: Codes 14 and 15 pass A through to the result and pass `flags_in` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Capture strobe |
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator value A |
| opnd_in | input | 8 | Second operand B |
| flags_in | input | 5 | Current flags {H,N,Z,V,C} |
| result_q | output | 8 | Registered result |
| flags_q | output | 5 | Registered flags {H,N,Z,V,C} |

## Verification
The bench sweeps all 256 accumulator values through every operation code, with 16 operand and flag combinations for each. That reaches the signed-overflow boundaries 0x7F/0x80 in both directions, the zero and 0x80 cases of negate, and every carry and half-carry combination of the decimal adjust. A design that clears C in decimal adjust, or fails to apply the 0x60 correction for a high nibble of 9 with a low nibble above 9, returns a wrong BCD result or a wrong carry. A design that takes V from the carry alone on shifts, takes the rotate fill from the wrong end, or lets increment and decrement touch C fails on many points of the sweep. Separate phases show that a low strobe and the reserved codes leave state untouched.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_ADC  = 4'h1,
        OP_SUB  = 4'h2,
        OP_SBC  = 4'h3,
        OP_INC  = 4'h4,
        OP_DEC  = 4'h5,
        OP_COM  = 4'h6,
        OP_NEG  = 4'h7,
        OP_ASL  = 4'h8,
        OP_ASR  = 4'h9,
        OP_LSR  = 4'hA,
        OP_ROL  = 4'hB,
        OP_ROR  = 4'hC,
        OP_DAA  = 4'hD,
        OP_RSV0 = 4'hE,
        OP_RSV1 = 4'hF
    } alu_op_e;

    // Packed flag order: bit4 H, bit3 N, bit2 Z, bit1 V, bit0 C
    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  ccr_t           fin,
    output logic [W-1:0]   res,
    output ccr_t           fout
);
    localparam int NIB = W / 2;
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    logic         carry_in;
    logic [W:0]   wide_add;
    logic [W:0]   wide_sub;
    logic [NIB:0] nib_add;

    always_comb begin
        carry_in = ((op == OP_ADC) || (op == OP_SBC)) ? fin.c : 1'b0;
        wide_add = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, carry_in};
        wide_sub = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, carry_in};
        nib_add  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, carry_in};
        res  = a;
        fout = fin;
        case (op)
            OP_ADD, OP_ADC: begin
                res    = wide_add[W-1:0];
                fout.c = wide_add[W];
                fout.h = nib_add[NIB];
                fout.v = (a[W-1] == b[W-1]) && (wide_add[W-1] != a[W-1]);
            end
            OP_SUB, OP_SBC: begin
                res    = wide_sub[W-1:0];
                fout.c = wide_sub[W];
                fout.v = (a[W-1] != b[W-1]) && (wide_sub[W-1] != a[W-1]);
            end
            OP_INC: begin
                res    = a + ONE;
                fout.v = (res == MIN_NEG);
            end
            OP_DEC: begin
                res    = a - ONE;
                fout.v = (res == MAX_POS);
            end
            OP_COM: begin
                res    = ~a;
                fout.v = 1'b0;
                fout.c = 1'b1;
            end
            OP_NEG: begin
                res    = {W{1'b0}} - a;
                fout.v = (res == MIN_NEG);
                fout.c = |res;
            end
            default: begin
                res  = a;
                fout = fin;
            end
        endcase
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  ccr_t         fin,
    output logic [W-1:0] res,
    output ccr_t         fout
);
    logic out_bit;
    logic moved;

    always_comb begin
        res     = a;
        out_bit = fin.c;
        moved   = 1'b1;
        case (op)
            OP_ASL: begin res = {a[W-2:0], 1'b0};    out_bit = a[W-1]; end
            OP_ROL: begin res = {a[W-2:0], fin.c};   out_bit = a[W-1]; end
            OP_ASR: begin res = {a[W-1], a[W-1:1]};  out_bit = a[0];   end
            OP_LSR: begin res = {1'b0, a[W-1:1]};    out_bit = a[0];   end
            OP_ROR: begin res = {fin.c, a[W-1:1]};   out_bit = a[0];   end
            default: moved = 1'b0;
        endcase
        fout = fin;
        if (moved) begin
            fout.c = out_bit;
            fout.v = res[W-1] ^ out_bit;
        end
    end

endmodule

// File: rtl/alu8_daa.sv
module alu8_daa
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  ccr_t         fin,
    output logic [W-1:0] res,
    output ccr_t         fout
);
    localparam int NIB = W / 2;
    localparam logic [NIB-1:0] NINE  = NIB'(9);
    localparam logic [NIB-1:0] EIGHT = NIB'(8);
    localparam logic [NIB-1:0] SIX   = NIB'(6);

    logic [NIB-1:0] lo_nib;
    logic [NIB-1:0] hi_nib;
    logic           lo_big;
    logic [W-1:0]   corr;
    logic [W:0]     adj_sum;

    always_comb begin
        lo_nib = a[NIB-1:0];
        hi_nib = a[W-1:NIB];
        lo_big = (lo_nib > NINE);
        corr   = {W{1'b0}};
        if (lo_big || fin.h)
            corr[NIB-1:0] = SIX;
        if ((hi_nib > NINE) || fin.c || ((hi_nib > EIGHT) && lo_big))
            corr[W-1:NIB] = SIX;
        adj_sum = {1'b0, a} + {1'b0, corr};
        res     = adj_sum[W-1:0];
        fout    = fin;
        fout.v  = 1'b0;
        fout.c  = fin.c | adj_sum[W];
    end

endmodule

// File: rtl/alu8_cc.sv
module alu8_cc
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [4:0]        flags_in,
    output logic [DATA_W-1:0] result_q,
    output logic [4:0]        flags_q
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        ccr_t              ccr;
    } stage_t;

    stage_t stage_d, stage_q;

    alu_op_e op;
    ccr_t    fin;
    assign op  = alu_op_e'(op_sel);
    assign fin = ccr_t'(flags_in);

    logic [DATA_W-1:0] arith_res, shift_res, daa_res;
    ccr_t              arith_f, shift_f, daa_f;

    alu8_arith #(.W(DATA_W)) u_arith (
        .op(op), .a(acc_in), .b(opnd_in), .fin(fin), .res(arith_res), .fout(arith_f)
    );

    alu8_shift #(.W(DATA_W)) u_shift (
        .op(op), .a(acc_in), .fin(fin), .res(shift_res), .fout(shift_f)
    );

    alu8_daa #(.W(DATA_W)) u_daa (
        .a(acc_in), .fin(fin), .res(daa_res), .fout(daa_f)
    );

    always_comb begin
        stage_d = stage_q;
        if (valid_in) begin
            case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBC,
                OP_INC, OP_DEC, OP_COM, OP_NEG: begin
                    stage_d.res = arith_res;
                    stage_d.ccr = arith_f;
                end
                OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
                    stage_d.res = shift_res;
                    stage_d.ccr = shift_f;
                end
                OP_DAA: begin
                    stage_d.res = daa_res;
                    stage_d.ccr = daa_f;
                end
                default: begin
                    stage_d.res = acc_in;
                    stage_d.ccr = fin;
                end
            endcase
            if ((op != OP_RSV0) && (op != OP_RSV1)) begin
                stage_d.ccr.n = stage_d.res[DATA_W-1];
                stage_d.ccr.z = (stage_d.res == {DATA_W{1'b0}});
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assign result_q = stage_q.res;
    assign flags_q  = stage_q.ccr;

endmodule

// File: rtl/alu8_cc_chk.sv
module alu8_cc_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_in,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic [4:0]        flags_in,
    input logic [DATA_W-1:0] result_q,
    input logic [4:0]        flags_q
);
    logic is_shift;
    assign is_shift = (op_sel >= 4'h8) && (op_sel <= 4'hC);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(result_q) && $stable(flags_q)));

    assert_inc_dec_keep_c_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_in && (op_sel == 4'h4 || op_sel == 4'h5))
        |=> (flags_q[0] == $past(flags_in[0]) && flags_q[4] == $past(flags_in[4])));

    assert_invert_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op_sel == 4'h6) |=> (flags_q[1] == 1'b0 && flags_q[0] == 1'b1));

    assert_shift_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (valid_in && is_shift) |=> (flags_q[1] == (flags_q[3] ^ flags_q[0])));

    assert_daa_carry_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op_sel == 4'hD && flags_in[0]) |=> flags_q[0]);

    assert_nz_follow_R13: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op_sel <= 4'hD)
        |=> (flags_q[3] == result_q[DATA_W-1] && flags_q[2] == (result_q == '0)));

    assert_reserved_pass_R14: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op_sel >= 4'hE)
        |=> (result_q == $past(acc_in) && flags_q == $past(flags_in)));

    logic unused_ok;
    assign unused_ok = ^opnd_in;

endmodule

bind alu8_cc alu8_cc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .valid_in(valid_in), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
    .result_q(result_q), .flags_q(flags_q)
);

// File: tb/tb_alu8_cc.sv
`timescale 1ns/1ps
module tb_alu8_cc;
    logic       clk = 1'b0;
    logic       rst;
    logic       valid_in;
    logic [3:0] op_sel;
    logic [7:0] acc_in, opnd_in;
    logic [4:0] flags_in;
    logic [7:0] result_q;
    logic [4:0] flags_q;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    alu8_cc dut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .op_sel(op_sel),
        .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
        .result_q(result_q), .flags_q(flags_q)
    );

    // Reference: returns {result[7:0], H, N, Z, V, C}
    function automatic logic [12:0] model(input int op, input int a, input int b, input int f);
        int h, n, z, v, c, r, t, lo, hi, cin;
        h = (f >> 4) & 1; n = (f >> 3) & 1; z = (f >> 2) & 1; v = (f >> 1) & 1; c = f & 1;
        r = a;
        cin = 0;
        case (op)
            0, 1: begin
                cin = (op == 1) ? c : 0;
                t = a + b + cin;
                r = t % 256;
                c = (t > 255) ? 1 : 0;
                h = ((a % 16) + (b % 16) + cin > 15) ? 1 : 0;
                v = ((a >= 128) == (b >= 128) && (r >= 128) != (a >= 128)) ? 1 : 0;
            end
            2, 3: begin
                cin = (op == 3) ? c : 0;
                t = a - b - cin;
                r = (t + 512) % 256;
                c = (t < 0) ? 1 : 0;
                v = ((a >= 128) != (b >= 128) && (r >= 128) != (a >= 128)) ? 1 : 0;
            end
            4: begin r = (a + 1) % 256; v = (r == 128) ? 1 : 0; end
            5: begin r = (a + 255) % 256; v = (r == 127) ? 1 : 0; end
            6: begin r = 255 - a; v = 0; c = 1; end
            7: begin r = (256 - a) % 256; v = (r == 128) ? 1 : 0; c = (r != 0) ? 1 : 0; end
            8:  begin r = (a * 2) % 256;         c = a / 128; end
            9:  begin r = a / 2 + (a / 128) * 128; c = a % 2; end
            10: begin r = a / 2;                 c = a % 2; end
            11: begin r = (a * 2) % 256 + c;     c = a / 128; end
            12: begin r = a / 2 + c * 128;       c = a % 2; end
            13: begin
                lo = a % 16; hi = a / 16; t = a;
                if (lo > 9 || h == 1) t = t + 6;
                if (hi > 9 || c == 1 || (hi > 8 && lo > 9)) t = t + 96;
                r = t % 256;
                if (t > 255) c = 1;
                v = 0;
            end
            default: ;
        endcase
        if (op >= 8 && op <= 12) v = ((r / 128) != c) ? 1 : 0;
        if (op <= 13) begin
            n = r / 128;
            z = (r == 0) ? 1 : 0;
        end
        return {r[7:0], h[0], n[0], z[0], v[0], c[0]};
    endfunction

    function automatic string req_tag(input int op);
        case (op)
            0, 1:   return "R3,R4,R13";
            2, 3:   return "R3,R5,R13";
            4, 5:   return "R3,R6,R13";
            6:      return "R3,R7,R13";
            7:      return "R3,R8,R13";
            8, 9, 10, 11, 12: return "R3,R9,R10,R13";
            13:     return "R3,R11,R12,R13";
            default: return "R14";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] er, input logic [4:0] ef);
        checks++;
        if (result_q !== er || flags_q !== ef) begin
            errors++;
            $display("FAIL %s: result=%02h flags=%05b expected result=%02h flags=%05b",
                     tag, result_q, flags_q, er, ef);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [12:0] exp_v;
        rst = 1'b1; valid_in = 1'b1; op_sel = 4'h6; acc_in = 8'h00;
        opnd_in = 8'h00; flags_in = 5'h1F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", 8'h00, 5'h00);

        rst = 1'b0;
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int j = 0; j < 16; j++) begin
                    op_sel   = op[3:0];
                    acc_in   = a[7:0];
                    opnd_in  = 8'((j * 73 + a * 5) % 256);
                    flags_in = 5'((j * 5 + a) % 32);
                    exp_v    = model(op, a, int'(opnd_in), int'(flags_in));
                    @(negedge clk);
                    check(req_tag(op), exp_v[12:5], exp_v[4:0]);
                end
            end
        end

        // R2: strobe low keeps the last captured value
        op_sel = 4'h0; acc_in = 8'h7F; opnd_in = 8'h01; flags_in = 5'h00;
        exp_v = model(0, 127, 1, 0);
        @(negedge clk);
        check("R2 capture", exp_v[12:5], exp_v[4:0]);
        valid_in = 1'b0; op_sel = 4'h7; acc_in = 8'h00; flags_in = 5'h1F;
        repeat (3) @(negedge clk);
        check("R2 hold", exp_v[12:5], exp_v[4:0]);

        // R1: reset clears, even with strobe high
        valid_in = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears", 8'h00, 5'h00);
        rst = 1'b0;

        // R12: carry stays set when the adjusted sum does not overflow
        op_sel = 4'hD; acc_in = 8'h12; flags_in = 5'h01;
        @(negedge clk);
        check("R12 sticky carry", 8'h72, 5'b00001);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule